// File: doc/BRIEF.md
# Multi-Port Audio Serial Receiver With 24-Bit Word Alignment

This block turns several I2S serial data lines into parallel 24-bit audio words. All lanes are timed by one receive bit clock and one left/right word-select clock, both produced by a shared clock generator. The bit clock reaches the block as a one-cycle strobe, `bclk_rise`, in the system clock domain. Each lane is captured at the rising bit-clock edges that this strobe marks.

Every word is normalised to 24 bits. Software sets the number of bits to keep per channel slot. Captured bits are placed MSB first from bit 23 downward. Positions that receive no bit stay zero, and bits beyond the 24th are discarded. Each lane has its own holding register, a flag showing which channel the word came from, a ready flag and a sticky overflow flag. A loopback control feeds the transmitter's serial outputs into the lanes in place of the external pins, for self-test.

A port starts capturing only at a word-select transition, so it never delivers a partial word. The first transition after reset only starts capture. Each following transition completes the word of the slot that just ended. The bit sampled at a transition is the last bit of the slot that is ending. The next bit is the MSB of the new slot.

Top module: `i2s_rx_multi`

## Requirements
- R1: Bits are taken MSB first. The k-th bit after a slot's start (k counted from 0) goes to word bit 23-k, provided k is below both `word_len` and 24. `word_len` ranges from 1 to 32.
- R2: When fewer than 24 bits are taken, because `word_len` is below 24 or the slot is shorter than 24 bits, the unfilled low bits of the word are zero.
- R3: When a slot carries more than 24 bits and `word_len` exceeds 24, only the first 24 bits are kept, and the later bits have no effect on the word.
- R4: All ports share `bclk_rise` and `lrclk` and capture their own data line independently. Every enabled port delivers every complete slot, in order.
- R5: The cycle after the `bclk_rise` that sees `lrclk` differ from its previous sampled level, an armed port loads its word and sets `rx_ready`. It also loads `rx_right` with the ended slot's `lrclk` level (1 = high slot).
- R6: A one-cycle `rd_ack` pulse clears that port's `rx_ready` on the next cycle, unless a new word completes in the same cycle.
- R7: If a word completes while `rx_ready` is set and not being read, `rx_ovf` sets and the new word replaces the old one. `rx_ovf` stays set until a one-cycle pulse on `ovf_clr` for that port. That pulse leaves `rx_ready` unchanged.
- R8: With `loop_en` high, each port captures `tx_sdout` in place of `sdin`, and `sdin` has no effect.
- R9: A port with `rx_en` low delivers nothing and keeps its word and flags. A port enabled mid-slot discards that slot and starts at the next `lrclk` transition.
- R10: After reset every word, ready flag and overflow flag is zero. The first `lrclk` transition after reset delivers no word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bclk_rise | input | 1 | One-cycle strobe marking a rising bit-clock edge |
| lrclk | input | 1 | Word-select level (0 = left slot, 1 = right slot) |
| sdin | input | NPORTS | External serial data, one line per port |
| tx_sdout | input | NPORTS | Transmitter serial outputs used in loopback |
| loop_en | input | 1 | Selects `tx_sdout` as the data source |
| rx_en | input | NPORTS | Per-port receive enable |
| word_len | input | LENW | Bits kept per slot, 1 to 32 |
| rd_ack | input | NPORTS | Read strobe per port; clears the ready flag |
| ovf_clr | input | NPORTS | Write-one-to-clear for the overflow flags |
| rx_word | output | NPORTS*AW | Received words, port p at bits [p*AW +: AW] |
| rx_right | output | NPORTS | Channel of the held word (1 = right) |
| rx_ready | output | NPORTS | A new word is held and unread |
| rx_ovf | output | NPORTS | Sticky overflow flag |

## Verification
The hardest situation to reach is a port that is switched on in the middle of a slot. It must throw away the half-captured slot and resume cleanly at the next word-select edge, while its neighbours keep delivering. The bench reaches it by changing the enable mask halfway through a slot's bit stream. It leaves that port out of the expected queue for the slot in progress, then includes it again from the following slot. Overflow is reached by pausing the reading monitor across two slots, then checking the replaced word, the sticky flag and its clear.

// File: rtl/i2s_rx_pkg.sv
package i2s_rx_pkg;
  // Width of the normalised audio word.
  parameter int unsigned RX_AW = 24;

  // Per-bit-clock framing event shared by all lanes.
  typedef struct packed {
    logic tick;       // rising bit-clock edge this cycle
    logic edge_seen;  // word-select changed at this edge
    logic level;      // word-select level of the slot that is ending
  } rx_frame_ev_t;
endpackage

// File: rtl/i2s_rx_frame.sv
module i2s_rx_frame
  import i2s_rx_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bclk_rise,
  input  logic         lrclk,
  output rx_frame_ev_t ev
);
  logic lr_q, lr_d;
  logic seen_q, seen_d;

  always_comb begin
    lr_d   = lr_q;
    seen_d = seen_q;
    if (bclk_rise) begin
      lr_d   = lrclk;
      seen_d = 1'b1;
    end
    ev.tick      = bclk_rise;
    ev.edge_seen = bclk_rise & seen_q & (lrclk != lr_q);
    ev.level     = lr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lr_q   <= 1'b0;
      seen_q <= 1'b0;
    end else begin
      lr_q   <= lr_d;
      seen_q <= seen_d;
    end
  end
endmodule

// File: rtl/i2s_rx_lane.sv
module i2s_rx_lane
  import i2s_rx_pkg::*;
#(
  parameter int unsigned AW   = RX_AW,
  parameter int unsigned LENW = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  rx_frame_ev_t    ev,
  input  logic            en,
  input  logic            sd,
  input  logic [LENW-1:0] len,
  output logic            done,
  output logic            done_right,
  output logic [AW-1:0]   done_word
);
  localparam int unsigned CW = LENW + 1;

  logic          armed_q, armed_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [AW-1:0] sh_q, sh_d;
  logic [AW-1:0] sh_ins;
  logic          keep;

  // Place the current bit at its MSB-first position when it is kept.
  always_comb begin
    keep   = (cnt_q < {1'b0, len}) && (cnt_q < CW'(AW));
    sh_ins = sh_q;
    for (int b = 0; b < int'(AW); b++) begin
      if (keep && (int'(cnt_q) == b)) sh_ins[AW-1-b] = sd;
    end
  end

  assign done       = ev.edge_seen & armed_q & en;
  assign done_right = ev.level;
  assign done_word  = sh_ins;

  always_comb begin
    armed_d = armed_q;
    cnt_d   = cnt_q;
    sh_d    = sh_q;
    if (!en) begin
      armed_d = 1'b0;
      cnt_d   = '0;
      sh_d    = '0;
    end else if (ev.edge_seen) begin
      armed_d = 1'b1;
      cnt_d   = '0;
      sh_d    = '0;
    end else if (ev.tick && armed_q) begin
      sh_d = sh_ins;
      if (cnt_q != '1) cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
      sh_q    <= '0;
    end else begin
      armed_q <= armed_d;
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
    end
  end
endmodule

// File: rtl/i2s_rx_port_regs.sv
module i2s_rx_port_regs #(
  parameter int unsigned AW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          done,
  input  logic          done_right,
  input  logic [AW-1:0] done_word,
  input  logic          rd,
  input  logic          ovf_clr,
  output logic [AW-1:0] word,
  output logic          right,
  output logic          ready,
  output logic          ovf
);
  logic [AW-1:0] word_d;
  logic          right_d, ready_d, ovf_d;

  always_comb begin
    word_d  = word;
    right_d = right;
    if (done) begin
      word_d  = done_word;
      right_d = done_right;
    end
    ready_d = done | (ready & ~rd);
    ovf_d   = (done & ready & ~rd) | (ovf & ~ovf_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word  <= '0;
      right <= 1'b0;
      ready <= 1'b0;
      ovf   <= 1'b0;
    end else begin
      word  <= word_d;
      right <= right_d;
      ready <= ready_d;
      ovf   <= ovf_d;
    end
  end
endmodule

// File: rtl/i2s_rx_multi.sv
module i2s_rx_multi
  import i2s_rx_pkg::*;
#(
  parameter int unsigned NPORTS = 6,
  parameter int unsigned AW     = RX_AW,
  parameter int unsigned LENW   = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bclk_rise,
  input  logic                 lrclk,
  input  logic [NPORTS-1:0]    sdin,
  input  logic [NPORTS-1:0]    tx_sdout,
  input  logic                 loop_en,
  input  logic [NPORTS-1:0]    rx_en,
  input  logic [LENW-1:0]      word_len,
  input  logic [NPORTS-1:0]    rd_ack,
  input  logic [NPORTS-1:0]    ovf_clr,
  output logic [NPORTS*AW-1:0] rx_word,
  output logic [NPORTS-1:0]    rx_right,
  output logic [NPORTS-1:0]    rx_ready,
  output logic [NPORTS-1:0]    rx_ovf
);
  logic [1:0]        rst_sync_q;
  logic              rst_i;
  rx_frame_ev_t      ev;
  logic [NPORTS-1:0] sd_sel;
  logic [NPORTS-1:0] lane_done;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i = rst_sync_q[1];

  i2s_rx_frame u_frame (
    .clk      (clk),
    .rst_n    (rst_i),
    .bclk_rise(bclk_rise),
    .lrclk    (lrclk),
    .ev       (ev)
  );

  for (genvar p = 0; p < int'(NPORTS); p++) begin : g_port
    logic          done_right;
    logic [AW-1:0] done_word;

    assign sd_sel[p] = loop_en ? tx_sdout[p] : sdin[p];

    i2s_rx_lane #(.AW(AW), .LENW(LENW)) u_lane (
      .clk       (clk),
      .rst_n     (rst_i),
      .ev        (ev),
      .en        (rx_en[p]),
      .sd        (sd_sel[p]),
      .len       (word_len),
      .done      (lane_done[p]),
      .done_right(done_right),
      .done_word (done_word)
    );

    i2s_rx_port_regs #(.AW(AW)) u_regs (
      .clk       (clk),
      .rst_n     (rst_i),
      .done      (lane_done[p]),
      .done_right(done_right),
      .done_word (done_word),
      .rd        (rd_ack[p]),
      .ovf_clr   (ovf_clr[p]),
      .word      (rx_word[p*AW +: AW]),
      .right     (rx_right[p]),
      .ready     (rx_ready[p]),
      .ovf       (rx_ovf[p])
    );
  end
endmodule

// File: rtl/i2s_rx_multi_chk.sv
module i2s_rx_multi_chk #(
  parameter int unsigned NPORTS = 6,
  parameter int unsigned AW     = 24
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NPORTS-1:0]    lane_done,
  input logic [NPORTS-1:0]    rd_ack,
  input logic [NPORTS-1:0]    ovf_clr,
  input logic [NPORTS-1:0]    rx_en,
  input logic [NPORTS-1:0]    rx_ready,
  input logic [NPORTS-1:0]    rx_ovf,
  input logic [NPORTS*AW-1:0] rx_word
);
  for (genvar p = 0; p < int'(NPORTS); p++) begin : g_chk
    // R5
    ready_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_ready[p]) |-> $past(lane_done[p]));

    // R6
    read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_ack[p] && !lane_done[p]) |=> !rx_ready[p]);

    // R7
    ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_ovf[p]) |-> $past(lane_done[p] && rx_ready[p] && !rd_ack[p]));

    // R7
    ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_ovf[p] && !ovf_clr[p]) |=> rx_ovf[p]);

    // R9
    off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_en[p] |-> !lane_done[p]);

    // R9
    word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !lane_done[p] |=> $stable(rx_word[p*AW +: AW]));
  end
endmodule

bind i2s_rx_multi i2s_rx_multi_chk #(.NPORTS(NPORTS), .AW(AW)) u_chk (.*);

// File: tb/sim_i2s_rx_multi.sv
module sim_i2s_rx_multi;
  localparam int NP = 6;
  localparam int AW = 24;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           bclk_rise = 1'b0;
  logic           lrclk = 1'b0;
  logic [NP-1:0]  sdin = '0;
  logic [NP-1:0]  tx_sdout = '0;
  logic           loop_en = 1'b0;
  logic [NP-1:0]  rx_en = '0;
  logic [5:0]     word_len = 6'd24;
  logic [NP-1:0]  rd_ack = '0;
  logic [NP-1:0]  ovf_clr = '0;
  logic [NP*AW-1:0] rx_word;
  logic [NP-1:0]  rx_right, rx_ready, rx_ovf;

  always #10 clk = ~clk;

  i2s_rx_multi u0 (.*);

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  bit mon_on = 1'b0;
  bit rd_force = 1'b0;
  logic cur_lr = 1'b0;
  int slot_n = 0;
  int len_i = 24;
  logic [24:0] expq [NP][$];
  logic [24:0] last_exp [NP];

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [23:0] expw(input logic [31:0] v, input int s, input int len);
    logic [23:0] r = '0;
    for (int k = 0; k < s; k++)
      if (k < len && k < 24) r[23-k] = v[s-1-k];
    return r;
  endfunction

  function automatic logic [31:0] pat(input int p, input int n);
    return (32'h9E3779B9 * 32'(n + 1)) ^ (32'h01020304 << p) ^ 32'(p * 977);
  endfunction

  task automatic rise(input logic lr, input logic [NP-1:0] b);
    @(negedge clk);
    lrclk = lr;
    if (loop_en) begin tx_sdout = b; sdin = ~b; end
    else         begin sdin = b; tx_sdout = ~b; end
    bclk_rise = 1'b1;
    @(negedge clk);
    bclk_rise = 1'b0;
    @(negedge clk);
  endtask

  // Driver: one slot of s bits; pushes expected words for ports in push_m.
  task automatic send_slot(input int s, input logic [NP-1:0] push_m,
                           input logic [NP-1:0] en_mid);
    logic [31:0] v [NP];
    logic [NP-1:0] b;
    logic lvl = cur_lr;
    for (int p = 0; p < NP; p++) begin
      v[p] = pat(p, slot_n);
      last_exp[p] = {lvl, expw(v[p], s, len_i)};
      if (push_m[p]) expq[p].push_back(last_exp[p]);
    end
    slot_n++;
    for (int k = 0; k < s; k++) begin
      if (k == s / 2) rx_en = en_mid;
      for (int p = 0; p < NP; p++) b[p] = v[p][s-1-k];
      rise((k == s - 1) ? ~lvl : lvl, b);
    end
    cur_lr = ~lvl;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor: pops and compares each ready word, then reads it.
  logic [NP-1:0] just_read = '0;
  always @(negedge clk) begin
    logic [NP-1:0] rd_next;
    logic [24:0] e;
    rd_next = '0;
    for (int p = 0; p < NP; p++)
      if (just_read[p])
        check(!rx_ready[p], "R6", "ready cleared by read", 32'(rx_ready[p]), 0);
    just_read = '0;
    if (mon_on) begin
      for (int p = 0; p < NP; p++) begin
        if (rx_ready[p]) begin
          if (expq[p].size() == 0) begin
            check(1'b0, "R4", "unexpected word", {7'd0, rx_right[p], rx_word[p*AW +: AW]}, 0);
          end else begin
            e = expq[p].pop_front();
            check({rx_right[p], rx_word[p*AW +: AW]} == e, "R1/R5", $sformatf("port %0d word", p),
                  {7'd0, rx_right[p], rx_word[p*AW +: AW]}, {7'd0, e});
          end
          rd_next[p] = 1'b1;
        end
      end
      just_read = rd_next;
    end
    if (rd_force) rd_next = '1;
    rd_ack = rd_next;
  end

  initial begin
    #(20 * 200000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [23:0] held;
    idle(3);
    // R10 reset state
    check(rx_ready == '0, "R10", "ready in reset", 32'(rx_ready), 0);
    check(rx_ovf == '0, "R10", "ovf in reset", 32'(rx_ovf), 0);
    check(rx_word == '0, "R10", "word in reset", rx_word[31:0], 0);
    rst_n = 1'b1;
    idle(4);
    rx_en = '1;
    // Prime: first rise only sets the reference level; second is the first edge.
    rise(1'b1, '0);
    rise(1'b0, '0);
    cur_lr = 1'b0;
    idle(3);
    check(rx_ready == '0, "R10", "first edge delivers nothing", 32'(rx_ready), 0);
    mon_on = 1'b1;

    // R1, R4: full 24-bit words in 24-bit slots
    len_i = 24; word_len = 6'd24;
    repeat (4) send_slot(24, '1, '1);
    idle(4);
    // R2: short word length, long slot
    len_i = 16; word_len = 6'd16;
    repeat (2) send_slot(32, '1, '1);
    // R2: slot shorter than 24 bits
    len_i = 24; word_len = 6'd24;
    repeat (2) send_slot(16, '1, '1);
    // R3: truncation of long words
    len_i = 32; word_len = 6'd32;
    repeat (2) send_slot(32, '1, '1);
    len_i = 28; word_len = 6'd28;
    repeat (2) send_slot(32, '1, '1);
    idle(4);

    // R8: loopback source
    len_i = 24; word_len = 6'd24;
    loop_en = 1'b1;
    repeat (2) send_slot(24, '1, '1);
    loop_en = 1'b0;
    idle(4);

    // R9: port 2 disabled, then enabled mid-slot
    held = rx_word[2*AW +: AW];
    rx_en = 6'b111011;
    send_slot(24, 6'b111011, 6'b111011);
    idle(4);
    check(!rx_ready[2], "R9", "disabled port not ready", 32'(rx_ready[2]), 0);
    check(rx_word[2*AW +: AW] == held, "R9", "disabled port word held",
          32'(rx_word[2*AW +: AW]), 32'(held));
    send_slot(24, 6'b111011, 6'b111111);
    send_slot(24, '1, '1);
    send_slot(24, '1, '1);
    idle(4);

    // R7: overflow with the monitor paused
    mon_on = 1'b0;
    idle(2);
    send_slot(24, '0, '1);
    idle(3);
    check(rx_ready == '1, "R7", "ready before overflow", 32'(rx_ready), 32'h3F);
    check(rx_ovf == '0, "R7", "no overflow yet", 32'(rx_ovf), 0);
    send_slot(24, '0, '1);
    idle(3);
    check(rx_ovf == '1, "R7", "overflow set", 32'(rx_ovf), 32'h3F);
    check({rx_right[0], rx_word[0 +: AW]} == last_exp[0], "R7", "port 0 word replaced",
          {7'd0, rx_right[0], rx_word[0 +: AW]}, {7'd0, last_exp[0]});
    check({rx_right[5], rx_word[5*AW +: AW]} == last_exp[5], "R7", "port 5 word replaced",
          {7'd0, rx_right[5], rx_word[5*AW +: AW]}, {7'd0, last_exp[5]});
    idle(5);
    check(rx_ovf == '1, "R7", "overflow sticky", 32'(rx_ovf), 32'h3F);
    ovf_clr = 6'b000101;
    @(negedge clk);
    ovf_clr = '0;
    @(negedge clk);
    check(rx_ovf == 6'b111010, "R7", "selected overflow cleared", 32'(rx_ovf), 32'h3A);
    ovf_clr = '1;
    @(negedge clk);
    ovf_clr = '0;
    @(negedge clk);
    check(rx_ovf == '0, "R7", "overflow cleared", 32'(rx_ovf), 0);
    check(rx_ready == '1, "R7", "clear keeps ready", 32'(rx_ready), 32'h3F);
    rd_force = 1'b1;
    @(negedge clk);
    rd_force = 1'b0;
    idle(2);
    check(rx_ready == '0, "R6", "forced read clears ready", 32'(rx_ready), 0);
    mon_on = 1'b1;
    repeat (2) send_slot(24, '1, '1);
    idle(6);

    for (int p = 0; p < NP; p++)
      check(expq[p].size() == 0, "R4", $sformatf("port %0d all words seen", p),
            32'(expq[p].size()), 0);
    check(rx_ovf == '0, "R7", "no spurious overflow", 32'(rx_ovf), 0);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule